// File: doc/BRIEF.md
# Data Address Watchpoint Comparator

This block watches the load/store request stream of a processor core and raises a per-channel hit flag when a request touches a watched byte range. It holds two independent channels. Each channel has a 64-bit address register and a control register, both loaded through a single register-write port. The control register sets the watched length, the access kinds that count (load, store or both) and the privilege modes that count (user, supervisor, hypervisor).

The comparison is combinational from the request bus and the stored channel state. The result is captured in a flop, so the hit vector for a request is presented on the clock edge that accepts it. The pipeline that owns the request holds back completion of the access until that hit vector has been seen. This gives stop-before-access behaviour. Exception delivery and any debugger link live outside the block.

Top module: `dwp_watch`

## Requirements
- R1: Synchronous active-high `rst` clears every address and control register of both channels and drives `hit_vec` to zero. Cleared channels match no request.
- R2: The watched start address of a channel is its address register with bits [2:0] forced to zero. The range is therefore always aligned to 8 bytes.
- R3: Control bits [20:15] hold a 6-bit length code. The watched length is (code + 1) x 8 bytes, from 8 bytes for code 0 up to 512 bytes for code 63.
- R4: Control bit 6 allows stores (`acc_write`=1) to match and control bit 5 allows loads (`acc_write`=0) to match. A channel with both bits clear never matches.
- R5: Control bits 2, 1 and 0 allow matches in hypervisor (`acc_mode`=2), supervisor (`acc_mode`=1) and user (`acc_mode`=0) mode respectively. Only the bit for the current mode is consulted. `acc_mode`=3 never matches. A channel with all three bits clear never matches.
- R6: The request covers bytes [acc_addr, acc_addr + 2^acc_size), so `acc_size` 0, 1, 2, 3 means 1, 2, 4, 8 bytes. A hit needs this range to overlap the channel range [start, start + length). Sums are formed without 64-bit wraparound, so a range that runs past the top of the address space never matches address 0.
- R7: Bit i of `hit_vec` reports channel i alone. When both channels match one request, both bits are set together.
- R8: `hit_vec` is registered. It shows the result for the request sampled at the previous rising edge, and it is zero after any edge where `acc_valid` was low.
- R9: A write with `reg_we`=1 loads the address register (`reg_sel`=0) or the control register (`reg_sel`=1) of channel `reg_chan`. The new value governs requests from the next cycle on. A request in the same cycle as the write is compared against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_chan | input | 1 | Channel selected for the write |
| reg_sel | input | 1 | 0 = address register, 1 = control register |
| reg_wdata | input | 64 | Write data |
| acc_valid | input | 1 | Load/store request present |
| acc_addr | input | 64 | Request byte address |
| acc_size | input | 2 | log2 of request size in bytes |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_mode | input | 2 | 0 user, 1 supervisor, 2 hypervisor, 3 reserved |
| hit_vec | output | 2 | Per-channel hit, one cycle after the request |

## Verification
Each hit result is due exactly one rising edge after its request is driven. The bench drives every request on a falling edge and reads `hit_vec` at the next falling edge, half a period after the capturing edge. Register writes take effect at the edge that accepts them. The bench therefore computes each expected value from its own model of the registers as they stood when the request was driven. In the same-cycle write case it updates that model only after computing the expectation. Random traffic is clustered around the watched addresses so that overlaps at both range edges occur often.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
  localparam int LEN_LSB  = 15;
  localparam int LEN_W    = 6;
  localparam int WR_BIT   = 6;
  localparam int RD_BIT   = 5;
  localparam int HYP_BIT  = 2;
  localparam int SUP_BIT  = 1;
  localparam int USR_BIT  = 0;

  localparam logic [1:0] MODE_USR = 2'd0;
  localparam logic [1:0] MODE_SUP = 2'd1;
  localparam logic [1:0] MODE_HYP = 2'd2;

  typedef struct packed {
    logic [LEN_W-1:0] len_code;
    logic             wr_en;
    logic             rd_en;
    logic             hyp_en;
    logic             sup_en;
    logic             usr_en;
  } wctl_t;

  function automatic wctl_t unpack_ctl(input logic [63:0] w);
    wctl_t c;
    c.len_code = w[LEN_LSB +: LEN_W];
    c.wr_en    = w[WR_BIT];
    c.rd_en    = w[RD_BIT];
    c.hyp_en   = w[HYP_BIT];
    c.sup_en   = w[SUP_BIT];
    c.usr_en   = w[USR_BIT];
    return c;
  endfunction
endpackage

// File: rtl/dwp_chan_regs.sv
module dwp_chan_regs
  import dwp_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_addr,
  input  logic          wr_ctl,
  input  logic [63:0]   wdata,
  output logic [AW-1:0] start_o,
  output wctl_t         ctl_o
);
  localparam int HI_W = AW - 3;

  logic [HI_W-1:0] addr_hi_q;
  wctl_t           ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hi_q <= '0;
      ctl_q     <= '0;
    end else begin
      if (wr_addr) addr_hi_q <= wdata[AW-1:3];
      if (wr_ctl)  ctl_q     <= unpack_ctl(wdata);
    end
  end

  assign start_o = {addr_hi_q, 3'b000};
  assign ctl_o   = ctl_q;
endmodule

// File: rtl/dwp_range_cmp.sv
module dwp_range_cmp
  import dwp_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic [AW-1:0]    start,
  input  logic [LEN_W-1:0] len_code,
  input  logic [AW-1:0]    acc_addr,
  input  logic [1:0]       acc_size,
  output logic             overlap
);
  localparam int XW = AW + 1;
  localparam int LW = LEN_W + 4;

  logic [LW-1:0] len_bytes;
  logic [XW-1:0] w_lo, w_hi, a_lo, a_hi;

  always_comb begin
    len_bytes = {1'b0, len_code, 3'b000} + LW'(8);
    w_lo      = {1'b0, start};
    w_hi      = w_lo + XW'(len_bytes);
    a_lo      = {1'b0, acc_addr};
    a_hi      = a_lo + (XW'(1) << acc_size);
    overlap   = (a_lo < w_hi) && (w_lo < a_hi);
  end
endmodule

// File: rtl/dwp_priv_filter.sv
module dwp_priv_filter
  import dwp_pkg::*;
(
  input  wctl_t      ctl,
  input  logic       acc_write,
  input  logic [1:0] acc_mode,
  output logic       permit
);
  logic kind_ok, mode_ok;

  always_comb begin
    kind_ok = acc_write ? ctl.wr_en : ctl.rd_en;
    case (acc_mode)
      MODE_USR: mode_ok = ctl.usr_en;
      MODE_SUP: mode_ok = ctl.sup_en;
      MODE_HYP: mode_ok = ctl.hyp_en;
      default:  mode_ok = 1'b0;
    endcase
    permit = kind_ok && mode_ok;
  end
endmodule

// File: rtl/dwp_watch.sv
module dwp_watch
  import dwp_pkg::*;
#(
  parameter int AW  = 64,
  parameter int NCH = 2,
  localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [CIW-1:0] reg_chan,
  input  logic           reg_sel,
  input  logic [63:0]    reg_wdata,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic [1:0]     acc_size,
  input  logic           acc_write,
  input  logic [1:0]     acc_mode,
  output logic [NCH-1:0] hit_vec
);
  logic [NCH-1:0][AW-1:0] ch_start;
  wctl_t [NCH-1:0]        ch_ctl;
  logic [NCH-1:0]         ch_match;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_me, overlap, permit;
    assign sel_me = reg_we && (reg_chan == CIW'(c));

    dwp_chan_regs #(.AW(AW)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_addr (sel_me && !reg_sel),
      .wr_ctl  (sel_me &&  reg_sel),
      .wdata   (reg_wdata),
      .start_o (ch_start[c]),
      .ctl_o   (ch_ctl[c])
    );

    dwp_range_cmp #(.AW(AW)) u_cmp (
      .start    (ch_start[c]),
      .len_code (ch_ctl[c].len_code),
      .acc_addr (acc_addr),
      .acc_size (acc_size),
      .overlap  (overlap)
    );

    dwp_priv_filter u_priv (
      .ctl       (ch_ctl[c]),
      .acc_write (acc_write),
      .acc_mode  (acc_mode),
      .permit    (permit)
    );

    assign ch_match[c] = overlap && permit;
  end

  always_ff @(posedge clk) begin
    if (rst)            hit_vec <= '0;
    else if (acc_valid) hit_vec <= ch_match;
    else                hit_vec <= '0;
  end
endmodule

// File: rtl/dwp_watch_chk.sv
module dwp_watch_chk
  import dwp_pkg::*;
#(
  parameter int AW  = 64,
  parameter int NCH = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   acc_valid,
  input logic [AW-1:0]          acc_addr,
  input logic [1:0]             acc_size,
  input logic                   acc_write,
  input logic [1:0]             acc_mode,
  input logic [NCH-1:0]         hit_vec,
  input logic [NCH-1:0][AW-1:0] ch_start,
  input wctl_t [NCH-1:0]        ch_ctl
);
  logic [AW:0] acc_end;
  assign acc_end = {1'b0, acc_addr} + ((AW+1)'(1) << acc_size);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_valid) |-> hit_vec == '0); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_KIND_GATE: assert property (@(posedge clk) disable iff (rst)
      hit_vec[c] |-> $past(acc_write ? ch_ctl[c].wr_en : ch_ctl[c].rd_en)); // R4

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      hit_vec[c] |-> $past(acc_mode) != 2'd3); // R5

    AST_MODE_GATE: assert property (@(posedge clk) disable iff (rst)
      hit_vec[c] |-> $past((acc_mode == MODE_USR && ch_ctl[c].usr_en) ||
                           (acc_mode == MODE_SUP && ch_ctl[c].sup_en) ||
                           (acc_mode == MODE_HYP && ch_ctl[c].hyp_en))); // R5

    AST_ABOVE_START: assert property (@(posedge clk) disable iff (rst)
      hit_vec[c] |-> $past(acc_end > {1'b0, ch_start[c]})); // R6
  end
endmodule

bind dwp_watch dwp_watch_chk #(.AW(AW), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .acc_size  (acc_size),
  .acc_write (acc_write),
  .acc_mode  (acc_mode),
  .hit_vec   (hit_vec),
  .ch_start  (ch_start),
  .ch_ctl    (ch_ctl)
);

// File: tb/dwp_watch_test.sv
module dwp_watch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [0:0]  reg_chan = '0;
  logic        reg_sel = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [63:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_mode = '0;
  logic [1:0]  hit_vec;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] m_addr [2];
  logic [63:0] m_ctl  [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dwp_watch uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_chan(reg_chan),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_write(acc_write),
    .acc_mode(acc_mode), .hit_vec(hit_vec)
  );

  function automatic logic [63:0] mk_ctl(int code, bit wr, bit rd, bit hy, bit sv, bit us);
    return (64'(code & 63) << 15) | (64'(wr) << 6) | (64'(rd) << 5) |
           (64'(hy) << 2) | (64'(sv) << 1) | 64'(us);
  endfunction

  function automatic bit exp_one(int c, logic [63:0] a, logic [1:0] s, bit w, logic [1:0] m);
    logic [64:0] st, en, lo, hi;
    bit kind, mode;
    st   = {1'b0, m_addr[c] & ~64'h7};
    en   = st + 65'((((m_ctl[c] >> 15) & 64'h3f) + 1) * 8);
    lo   = {1'b0, a};
    hi   = lo + (65'd1 << s);
    kind = w ? m_ctl[c][6] : m_ctl[c][5];
    mode = (m == 2'd0) ? m_ctl[c][0] : (m == 2'd1) ? m_ctl[c][1] :
           (m == 2'd2) ? m_ctl[c][2] : 1'b0;
    return kind && mode && (lo < en) && (st < hi);
  endfunction

  function automatic logic [1:0] exp_vec(bit v, logic [63:0] a, logic [1:0] s, bit w, logic [1:0] m);
    if (!v) return 2'b00;
    return {exp_one(1, a, s, w, m), exp_one(0, a, s, w, m)};
  endfunction

  task automatic check(logic [1:0] got, logic [1:0] exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: hit_vec=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic wr_reg(int c, bit sel, logic [63:0] d);
    reg_we = 1'b1; reg_chan = 1'(c); reg_sel = sel; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
    if (sel) m_ctl[c] = d; else m_addr[c] = d;
  endtask

  task automatic acc(bit v, logic [63:0] a, logic [1:0] s, bit w, logic [1:0] m, string tag);
    logic [1:0] e;
    e = exp_vec(v, a, s, w, m);
    acc_valid = v; acc_addr = a; acc_size = s; acc_write = w; acc_mode = m;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    check(hit_vec, e, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < 2; c++) begin m_addr[c] = '0; m_ctl[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(hit_vec, 2'b00, "R1 reset output");
    rst = 1'b0;
    acc(1, 64'h0, 2'd0, 0, 2'd0, "R1 cleared channel at address 0");

    // R2/R6: start 0x1003 -> 0x1000, 8 bytes, loads in user mode
    wr_reg(0, 0, 64'h1003);
    wr_reg(0, 1, mk_ctl(0, 0, 1, 0, 0, 1));
    acc(1, 64'h1000, 2'd0, 0, 2'd0, "R2 aligned start byte");
    acc(1, 64'h1007, 2'd0, 0, 2'd0, "R6 last byte");
    acc(1, 64'h1008, 2'd0, 0, 2'd0, "R6 one past end");
    acc(1, 64'h0FFF, 2'd0, 0, 2'd0, "R2 byte below start");
    acc(1, 64'h0FFF, 2'd1, 0, 2'd0, "R6 halfword straddle");
    acc(1, 64'h0FF8, 2'd3, 0, 2'd0, "R6 adjacent doubleword");
    // R3: 512-byte range
    wr_reg(0, 1, mk_ctl(63, 0, 1, 0, 0, 1));
    acc(1, 64'h11FF, 2'd0, 0, 2'd0, "R3 last of 512");
    acc(1, 64'h1200, 2'd0, 0, 2'd0, "R3 past 512");
    // R4: kind gating
    acc(1, 64'h1010, 2'd2, 1, 2'd0, "R4 store on load-only");
    wr_reg(0, 1, mk_ctl(63, 1, 0, 0, 0, 1));
    acc(1, 64'h1010, 2'd2, 1, 2'd0, "R4 store enabled");
    acc(1, 64'h1010, 2'd2, 0, 2'd0, "R4 load on store-only");
    wr_reg(0, 1, mk_ctl(63, 0, 0, 1, 1, 1));
    acc(1, 64'h1010, 2'd2, 0, 2'd2, "R4 no kind enabled");
    // R5: privilege gating
    wr_reg(0, 1, mk_ctl(63, 1, 1, 0, 0, 1));
    acc(1, 64'h1010, 2'd0, 0, 2'd1, "R5 supervisor on user-only");
    acc(1, 64'h1010, 2'd0, 0, 2'd3, "R5 reserved mode");
    wr_reg(0, 1, mk_ctl(63, 1, 1, 1, 0, 0));
    acc(1, 64'h1010, 2'd0, 0, 2'd2, "R5 hypervisor enabled");
    wr_reg(0, 1, mk_ctl(63, 1, 1, 0, 0, 0));
    acc(1, 64'h1010, 2'd0, 0, 2'd2, "R5 no mode enabled");
    // R7: both channels
    wr_reg(0, 1, mk_ctl(3, 1, 1, 1, 1, 1));
    wr_reg(1, 0, 64'h1018);
    wr_reg(1, 1, mk_ctl(0, 1, 1, 1, 1, 1));
    acc(1, 64'h101C, 2'd1, 1, 2'd1, "R7 both channels");
    acc(1, 64'h1000, 2'd1, 1, 2'd1, "R7 channel 0 only");
    // R8: idle request
    acc(0, 64'h101C, 2'd1, 1, 2'd1, "R8 valid low");
    // R6: top of address space, no wrap
    wr_reg(1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_reg(1, 1, mk_ctl(1, 1, 1, 1, 1, 1));
    acc(1, 64'h0, 2'd3, 0, 2'd0, "R6 no wraparound");
    acc(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 0, 2'd0, "R6 top byte");
    // R9: write and request in the same cycle use the old value
    begin
      logic [1:0] e;
      e = exp_vec(1, 64'h1000, 2'd0, 0, 2'd0);
      reg_we = 1'b1; reg_chan = 1'b0; reg_sel = 1'b1; reg_wdata = '0;
      acc_valid = 1'b1; acc_addr = 64'h1000; acc_size = 2'd0;
      acc_write = 1'b0; acc_mode = 2'd0;
      @(posedge clk); @(negedge clk);
      reg_we = 1'b0; acc_valid = 1'b0;
      m_ctl[0] = '0;
      check(hit_vec, e, "R9 same-cycle write sees old");
      acc(1, 64'h1000, 2'd0, 0, 2'd0, "R9 next cycle sees new");
    end
    // random traffic
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 5 == 0) begin
        int c;
        c = $urandom % 2;
        if ($urandom % 2 == 0) wr_reg(c, 0, 64'h4000 + 64'($urandom % 1024));
        else wr_reg(c, 1, mk_ctl($urandom % 64, 1'($urandom), 1'($urandom),
                                 1'($urandom), 1'($urandom), 1'($urandom)));
      end else begin
        acc(($urandom % 8) != 0, 64'h3E00 + 64'($urandom % 1536), 2'($urandom),
            1'($urandom), 2'($urandom), "R6 R7 random");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule